// File: doc/BRIEF.md
# Windowed Watchdog with Prescaler and Status Word

This block supervises software liveness with a windowed watchdog. A counter advances on a base tick and must be refreshed inside an open window. The period is the base count times a divisor. A 3-bit prescaler code, written through the watchdog side of a shared timing register, selects that divisor. Each period is split in two halves: the first half is a closed window and the second half is an open window. A refresh in the open window restarts the period. If the period expires, or if a refresh arrives while the window is closed, the block raises a one-cycle reset request and starts counting again.

The prescaler divisor applies only while windowed mode is selected. With windowed mode off, the period is the plain base count and a refresh is accepted at any time. A 4-bit status word reports four things:
- a timeout flag that survives the watchdog reset;
- an error flag that marks a closed-window refresh;
- the disabled state;
- the current window phase.

The status word is combinational, so a status read or a timing-register write returns the value as it was before the access. The access then clears the timeout and error flags on the next edge. The serial register interface and the rest of the reset generator live outside this block.

Top module: `window_watchdog`

## Requirements
- R1: After synchronous reset, with the watchdog enabled and windowed mode selected, `rst_req_o` is 0 and `status_o` is 4'b0000; the prescaler code is 000.
- R2: In windowed mode the period in ticks is BASE_COUNT times the divisor of the prescaler code. Codes 000..111 give divisors 1, 2, 4, 6, 8, 10, 12, 14. When ticks arrive every cycle and the count starts from zero, `rst_req_o` rises after exactly that many ticks.
- R3: A timing write with `tim_sel_i`=0 loads `tim_code_i` as the watchdog prescaler code. A timing write with `tim_sel_i`=1 leaves the watchdog code unchanged.
- R4: With `win_mode_i`=0 the code is ignored, the period is BASE_COUNT ticks, and a refresh at any count restarts the period without a reset request.
- R5: In windowed mode, a refresh while the count is below half the period gives the following on the next cycle: `rst_req_o`=1, the timeout flag set, the error flag set, and the count restarted.
- R6: A refresh while the window is open gives no reset request and restarts the full period.
- R7: Expiry gives a `rst_req_o` pulse of one cycle. It sets the timeout flag and clears the error flag.
- R8: The status bits are laid out as follows: `status_o[3]` is timeout, `[2]` is error, `[1]` is off (watchdog disabled) and `[0]` is window open. Window open is 1 when the block is enabled and either windowed mode is off or the count is at least half the period.
- R9: A cycle with `stat_rd_i` or `tim_wr_i` high shows the pre-access status on `status_o` and clears timeout and error at its edge. A reset event on the same edge wins, leaving the flag set.
- R10: While `wd_en_i`=0 the count is held at zero, no reset request is issued, and `status_o[1]`=1.
- R11: The count advances only on cycles with `tick_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_i | input | 1 | Base tick enable |
| wd_en_i | input | 1 | Watchdog enable |
| win_mode_i | input | 1 | Windowed mode select |
| tim_wr_i | input | 1 | Timing register write strobe |
| tim_sel_i | input | 1 | Timing write target: 0 watchdog, 1 other prescaler |
| tim_code_i | input | 3 | Prescaler code written |
| refresh_i | input | 1 | Watchdog refresh request |
| stat_rd_i | input | 1 | Status register read strobe |
| rst_req_o | output | 1 | One-cycle reset request |
| status_o | output | 4 | {timeout, error, off, window open} |

## Verification
The assertions check the following rules on every cycle:
- an early refresh is punished on the next cycle;
- an open-window refresh is never punished;
- a disabled watchdog stays silent;
- any access clears the flags unless a reset event lands on the same edge;
- the error flag never stands without the timeout flag.

Only the bench scenarios can show the following:
- the exact period length for each prescaler code;
- that a write aimed at the other prescaler leaves the period alone;
- where the window boundary sits;
- that ticks gate the count.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

    typedef struct packed {
        logic timeout;
        logic err;
        logic off;
        logic win_open;
    } wd_status_t;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_EXPIRE = 2'd1,
        EV_EARLY  = 2'd2
    } wd_event_e;

    localparam int MAX_DIV = 14;

    // code 0 -> 1, code n -> 2n
    function automatic logic [3:0] code_to_div(input logic [2:0] code);
        return (code == 3'd0) ? 4'd1 : {code, 1'b0};
    endfunction

endpackage

// File: rtl/wd_presc_reg.sv
module wd_presc_reg
    import wwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_i,
    input  logic       sel_i,
    input  logic [2:0] code_i,
    input  logic       win_mode_i,
    output logic [3:0] div_o
);
    logic [2:0] code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= 3'd0;
        end else if (wr_i && !sel_i) begin
            code_q <= code_i;
        end
    end

    always_comb begin
        div_o = win_mode_i ? code_to_div(code_q) : 4'd1;
    end
endmodule

// File: rtl/wd_timer.sv
module wd_timer
    import wwd_pkg::*;
#(
    parameter int BASE_COUNT = 16,
    parameter int CW         = $clog2(BASE_COUNT * MAX_DIV + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          en_i,
    input  logic          win_mode_i,
    input  logic          refresh_i,
    input  logic [3:0]    div_i,
    output wd_event_e     ev_o,
    output logic          win_open_o
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] period;
    logic [CW-1:0] half;

    always_comb begin
        period     = CW'(BASE_COUNT * int'(div_i));
        half       = period >> 1;
        win_open_o = en_i && (!win_mode_i || (cnt_q >= half));
        ev_o       = EV_NONE;
        if (en_i) begin
            if (refresh_i) begin
                if (win_mode_i && (cnt_q < half)) begin
                    ev_o = EV_EARLY;
                end
            end else if (tick_i && (cnt_q >= period - CW'(1))) begin
                ev_o = EV_EXPIRE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!en_i || refresh_i || (ev_o != EV_NONE)) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/wd_status.sv
module wd_status
    import wwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wd_event_e  ev_i,
    input  logic       access_i,
    input  logic       en_i,
    input  logic       win_open_i,
    output wd_status_t status_o,
    output logic       rst_req_o
);
    logic timeout_q;
    logic err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            timeout_q <= 1'b0;
            err_q     <= 1'b0;
            rst_req_o <= 1'b0;
        end else begin
            rst_req_o <= (ev_i != EV_NONE);
            if (ev_i == EV_EXPIRE) begin
                timeout_q <= 1'b1;
                err_q     <= 1'b0;
            end else if (ev_i == EV_EARLY) begin
                timeout_q <= 1'b1;
                err_q     <= 1'b1;
            end else if (access_i) begin
                timeout_q <= 1'b0;
                err_q     <= 1'b0;
            end
        end
    end

    always_comb begin
        status_o.timeout  = timeout_q;
        status_o.err      = err_q;
        status_o.off      = !en_i;
        status_o.win_open = win_open_i;
    end
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
    import wwd_pkg::*;
#(
    parameter int BASE_COUNT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       wd_en_i,
    input  logic       win_mode_i,
    input  logic       tim_wr_i,
    input  logic       tim_sel_i,
    input  logic [2:0] tim_code_i,
    input  logic       refresh_i,
    input  logic       stat_rd_i,
    output logic       rst_req_o,
    output logic [3:0] status_o
);
    localparam int CW = $clog2(BASE_COUNT * MAX_DIV + 1);

    logic [3:0] div;
    wd_event_e  ev;
    logic       win_open;
    wd_status_t stat;

    wd_presc_reg u_presc (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (tim_wr_i),
        .sel_i      (tim_sel_i),
        .code_i     (tim_code_i),
        .win_mode_i (win_mode_i),
        .div_o      (div)
    );

    wd_timer #(
        .BASE_COUNT (BASE_COUNT),
        .CW         (CW)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .en_i       (wd_en_i),
        .win_mode_i (win_mode_i),
        .refresh_i  (refresh_i),
        .div_i      (div),
        .ev_o       (ev),
        .win_open_o (win_open)
    );

    wd_status u_status (
        .clk        (clk),
        .rst        (rst),
        .ev_i       (ev),
        .access_i   (tim_wr_i || stat_rd_i),
        .en_i       (wd_en_i),
        .win_open_i (win_open),
        .status_o   (stat),
        .rst_req_o  (rst_req_o)
    );

    assign status_o = stat;
endmodule

// File: rtl/wd_chk.sv
module wd_chk (
    input logic       clk,
    input logic       rst,
    input logic       wd_en_i,
    input logic       win_mode_i,
    input logic       refresh_i,
    input logic       stat_rd_i,
    input logic       tim_wr_i,
    input logic       rst_req_o,
    input logic [3:0] status_o
);
    // R5
    early_refresh_chk: assert property (@(posedge clk) disable iff (rst)
        (wd_en_i && win_mode_i && refresh_i && !status_o[0])
        |=> (rst_req_o && status_o[3] && status_o[2]));

    // R6
    open_refresh_chk: assert property (@(posedge clk) disable iff (rst)
        (wd_en_i && refresh_i && status_o[0]) |=> !rst_req_o);

    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !wd_en_i |=> !rst_req_o);

    // R9
    access_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rd_i || tim_wr_i) |=> (!status_o[3] || rst_req_o));

    // R7
    req_flags_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> status_o[3]);

    // R8
    err_needs_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        status_o[2] |-> status_o[3]);
endmodule

bind window_watchdog wd_chk u_wd_chk (
    .clk        (clk),
    .rst        (rst),
    .wd_en_i    (wd_en_i),
    .win_mode_i (win_mode_i),
    .refresh_i  (refresh_i),
    .stat_rd_i  (stat_rd_i),
    .tim_wr_i   (tim_wr_i),
    .rst_req_o  (rst_req_o),
    .status_o   (status_o)
);

// File: tb/tb_window_watchdog.sv
module tb_window_watchdog;
    localparam int BASE = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b1;
    logic       wd_en_i = 1'b1;
    logic       win_mode_i = 1'b1;
    logic       tim_wr_i = 1'b0;
    logic       tim_sel_i = 1'b0;
    logic [2:0] tim_code_i = 3'd0;
    logic       refresh_i = 1'b0;
    logic       stat_rd_i = 1'b0;
    logic       rst_req_o;
    logic [3:0] status_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    // {code, expected period in ticks}
    localparam logic [8:0] VEC [8] = '{
        {3'd0, 6'd4},  {3'd1, 6'd8},  {3'd2, 6'd16}, {3'd3, 6'd24},
        {3'd4, 6'd32}, {3'd5, 6'd40}, {3'd6, 6'd48}, {3'd7, 6'd56}
    };

    window_watchdog #(.BASE_COUNT(BASE)) dut (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .wd_en_i    (wd_en_i),
        .win_mode_i (win_mode_i),
        .tim_wr_i   (tim_wr_i),
        .tim_sel_i  (tim_sel_i),
        .tim_code_i (tim_code_i),
        .refresh_i  (refresh_i),
        .stat_rd_i  (stat_rd_i),
        .rst_req_o  (rst_req_o),
        .status_o   (status_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_fail = n_fail + 1;
            n_tests = n_tests + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // edges until rst_req_o is seen high
    task automatic wait_rst(input int maxn, output int n);
        n = 0;
        while (n <= maxn) begin
            step();
            n++;
            if (rst_req_o) break;
        end
    endtask

    task automatic tim_write(input logic sel, input logic [2:0] code);
        tim_wr_i = 1'b1; tim_sel_i = sel; tim_code_i = code;
        step();
        tim_wr_i = 1'b0; tim_sel_i = 1'b0;
    endtask

    int n;
    int hits;

    initial begin
        repeat (3) step();
        rst = 1'b0;
        // R1 reset state
        check("R1 status", int'(status_o), 0);
        check("R1 rst_req", int'(rst_req_o), 0);

        // R7 expiry after BASE ticks with code 0
        wait_rst(100, n);
        check("R7 expiry period", n, 4);
        check("R7 flags timeout only", int'(status_o), 4'b1000);
        step();
        check("R7 one-cycle pulse", int'(rst_req_o), 0);

        // R9 read returns pre-clear value then clears
        stat_rd_i = 1'b1;
        check("R9 read returns timeout", int'(status_o[3]), 1);
        step();
        stat_rd_i = 1'b0;
        check("R9 read clears timeout", int'(status_o[3]), 0);

        // R2 period for every prescaler code
        for (int i = 0; i < 8; i++) begin
            tim_write(1'b0, VEC[i][8:6]);
            wait_rst(100, n);
            wait_rst(100, n);
            check($sformatf("R2 period code %0d", i), n, int'(VEC[i][5:0]));
        end

        // R3 write to other prescaler leaves code 7
        tim_write(1'b1, 3'd0);
        wait_rst(100, n);
        wait_rst(100, n);
        check("R3 sel=1 ignored", n, 56);
        tim_write(1'b0, 3'd0);
        wait_rst(100, n);

        // R8 window closed right after restart
        check("R8 closed at count 0", int'(status_o[0]), 0);
        // R5 early refresh
        refresh_i = 1'b1;
        step();
        refresh_i = 1'b0;
        check("R5 early refresh reset", int'(rst_req_o), 1);
        check("R5 early flags", int'(status_o), 4'b1100);
        // R6 open refresh
        step(); step();
        check("R8 open at half", int'(status_o[0]), 1);
        refresh_i = 1'b1;
        step();
        refresh_i = 1'b0;
        check("R6 no reset on open refresh", int'(rst_req_o), 0);
        check("R6 window closed after restart", int'(status_o[0]), 0);
        wait_rst(100, n);
        check("R6 full period restarted", n, 4);
        check("R7 expiry clears error", int'(status_o), 4'b1000);

        // R9 timing write returns status and clears
        tim_wr_i = 1'b1; tim_sel_i = 1'b1;
        check("R9 write returns status", int'(status_o), 4'b1000);
        step();
        tim_wr_i = 1'b0; tim_sel_i = 1'b0;
        check("R9 write clears timeout", int'(status_o[3]), 0);

        // R9 set wins over clear on same edge
        wait_rst(100, n);
        stat_rd_i = 1'b1; step(); stat_rd_i = 1'b0;
        step(); step();
        stat_rd_i = 1'b1; step(); stat_rd_i = 1'b0;
        check("R9 set-wins rst_req", int'(rst_req_o), 1);
        check("R9 set-wins timeout kept", int'(status_o[3]), 1);

        // R8 window boundary with code 3 (period 24, half 12)
        tim_write(1'b0, 3'd3);
        wait_rst(100, n);
        repeat (11) step();
        check("R8 closed at count 11", int'(status_o[0]), 0);
        step();
        check("R8 open at count 12", int'(status_o[0]), 1);

        // R4 non-windowed mode
        win_mode_i = 1'b0;
        tim_write(1'b0, 3'd7);
        wait_rst(100, n);
        wait_rst(100, n);
        check("R4 period ignores code", n, 4);
        check("R4 window always open", int'(status_o[0]), 1);
        refresh_i = 1'b1; step(); refresh_i = 1'b0;
        check("R4 refresh at count 0 accepted", int'(rst_req_o), 0);
        win_mode_i = 1'b1;
        tim_write(1'b0, 3'd0);

        // R10 disabled
        wd_en_i = 1'b0;
        step();
        check("R10 off bit", int'(status_o[1]), 1);
        hits = 0;
        for (int k = 0; k < 60; k++) begin
            if (k == 20) refresh_i = 1'b1;
            if (k == 21) refresh_i = 1'b0;
            step();
            if (rst_req_o) hits++;
        end
        check("R10 no reset while off", hits, 0);
        wd_en_i = 1'b1;
        wait_rst(100, n);
        check("R10 restart from zero", n, 4);

        // R11 tick gating
        tick_i = 1'b0;
        hits = 0;
        for (int k = 0; k < 30; k++) begin
            step();
            if (rst_req_o) hits++;
        end
        check("R11 no expiry without ticks", hits, 0);
        tick_i = 1'b1;
        wait_rst(100, n);
        check("R11 count held", n, 4);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule